// File: doc/BRIEF.md
# Requester-to-Stream ID Mapping Table

This block translates the 16-bit requester ID carried by an inbound PCIe transaction (bus in bits 15:8, device in bits 7:3, function in bits 2:0) into a stream ID for a downstream IOMMU. Software programs the table through a simple 32-bit register port. Each slot holds a valid flag, an 8-bit stream ID and a requester ID. When a lookup strobe arrives, the presented requester ID is compared at once against every valid slot.

A hit returns the stream ID of the matching slot on the cycle after the strobe. A miss raises a one-cycle mapping-error pulse instead. The address window has room for 64 slots, but only the first `NUM_IMPL` are built. The slots above that read as zero and drop writes, so software can find the table depth by writing a slot and reading it back.

Top module: `rid_sid_map`

## Requirements
- R1: After reset every implemented slot reads as zero, and any lookup misses.
- R2: Slot i is at byte offset 0x828 + 4·i. A write stores bit 31 as the valid flag, bits 23:16 as the stream ID and bits 15:0 as the requester ID. A read of an implemented slot returns the written value when bits 30:24 were zero, and the read data follows the address in the same cycle.
- R3: Bits 30:24 of every read return zero, whatever was written to them.
- R4: Reads return zero and writes have no effect for any of these addresses: a slot index at or above `NUM_IMPL` (up to index 63), an address outside the window, or an address that is not word aligned.
- R5: When `lk_req` is high at a clock edge, `lk_done` is high in the next cycle. If a valid slot matches, `lk_hit` is 1 and `lk_sid` carries that slot's stream ID.
- R6: On a miss, `map_err` is high for exactly the result cycle, `lk_hit` is 0 and `lk_sid` is 0.
- R7: Only slots whose valid flag is set take part in matching. Writing zero to a slot invalidates it.
- R8: When several valid slots match, the slot with the lowest index supplies the stream ID.
- R9: All 16 bits of the requester ID are compared. An ID that differs in any single bit misses.
- R10: A lookup in the same cycle as a write uses the table contents from before that write.
- R11: In a cycle that does not follow a lookup strobe, `lk_done`, `lk_hit` and `map_err` are 0 and `lk_sid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| lk_req | input | 1 | Lookup strobe |
| lk_rid | input | 16 | Requester ID to translate |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_sid | output | 8 | Stream ID of the lowest matching slot |
| map_err | output | 1 | Mapping-error pulse on a miss |

## Verification
A register write and a lookup strobe can land on the same clock edge. The two can also target the same slot, which happens when software invalidates or remaps a slot while traffic is still in flight. The bench provokes this by clearing slot 1 in the very cycle that it strobes a lookup of slot 1's requester ID. The correct result is a hit carrying the old stream ID. A second lookup right after it must then miss and pulse the mapping error.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  // Field widths are fixed by the 32-bit slot word layout.
  localparam int RID_W = 16;
  localparam int SID_W = 8;

  typedef struct packed {
    logic             vld;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
  } rsm_entry_t;

  // Reserved bits 30:24 always read back as zero.
  function automatic logic [31:0] entry_to_word(rsm_entry_t e);
    return {e.vld, 7'b0, e.sid, e.rid};
  endfunction

  function automatic rsm_entry_t word_to_entry(logic [31:0] w);
    rsm_entry_t e;
    e.vld = w[31];
    e.sid = w[23:16];
    e.rid = w[15:0];
    return e;
  endfunction
endpackage

// File: rtl/rsm_decode.sv
module rsm_decode #(
  parameter int ADDR_W = 12,
  parameter int NUM_SLOTS = 64,
  parameter int NUM_IMPL = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 12'h828,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              slot_ok,
  output logic [IDX_W-1:0]  slot_idx
);
  localparam int SPAN = 4 * NUM_SLOTS;

  logic [ADDR_W-1:0] offset;
  logic [31:0]       offset_ext;
  logic [31:0]       idx_ext;
  logic              in_window;

  always_comb begin
    offset     = addr - TABLE_BASE;
    offset_ext = {{(32-ADDR_W){1'b0}}, offset};
    slot_idx   = offset[IDX_W+1:2];
    idx_ext    = {{(32-IDX_W){1'b0}}, slot_idx};
    in_window  = (addr >= TABLE_BASE) && (offset_ext < 32'(SPAN)) && (offset[1:0] == 2'b00);
    slot_ok    = in_window && (idx_ext < 32'(NUM_IMPL));
  end
endmodule

// File: rtl/rsm_bank.sv
module rsm_bank
  import rsm_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int NUM_IMPL = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_word,
  input  logic             rd_ok,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output rsm_entry_t       entries [NUM_IMPL]
);
  for (genvar i = 0; i < NUM_IMPL; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries[i] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        entries[i] <= word_to_entry(wr_word);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_IMPL; i++) begin
      if (rd_ok && (rd_idx == IDX_W'(i))) rd_word = entry_to_word(entries[i]);
    end
  end
endmodule

// File: rtl/rsm_match.sv
module rsm_match
  import rsm_pkg::*;
#(
  parameter int NUM_IMPL = 16
) (
  input  rsm_entry_t       entries [NUM_IMPL],
  input  logic [RID_W-1:0] rid,
  output logic [NUM_IMPL-1:0] match_vec,
  output logic [NUM_IMPL-1:0] sel_onehot,
  output logic             any_match,
  output logic [SID_W-1:0] sel_sid
);
  always_comb begin
    for (int i = 0; i < NUM_IMPL; i++) begin
      match_vec[i] = entries[i].vld && (entries[i].rid == rid);
    end
    // Isolate the lowest set bit: lowest index wins.
    sel_onehot = match_vec & (~match_vec + NUM_IMPL'(1));
    any_match  = |match_vec;
    sel_sid    = '0;
    for (int i = 0; i < NUM_IMPL; i++) begin
      if (sel_onehot[i]) sel_sid = sel_sid | entries[i].sid;
    end
  end
endmodule

// File: rtl/rid_sid_map.sv
module rid_sid_map
  import rsm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_SLOTS = 64,
  parameter int NUM_IMPL = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 12'h828
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_req,
  input  logic [RID_W-1:0]  lk_rid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [SID_W-1:0]  lk_sid,
  output logic              map_err
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic                slot_ok;
  logic [IDX_W-1:0]    slot_idx;
  logic                wr_fire;
  rsm_entry_t          entries [NUM_IMPL];
  logic [NUM_IMPL-1:0] match_vec;
  logic [NUM_IMPL-1:0] sel_onehot;
  logic                any_match;
  logic [SID_W-1:0]    sel_sid;

  rsm_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .NUM_IMPL(NUM_IMPL), .TABLE_BASE(TABLE_BASE)
  ) u_dec (
    .addr(cfg_addr), .slot_ok(slot_ok), .slot_idx(slot_idx)
  );

  assign wr_fire = cfg_we && slot_ok;

  rsm_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_IMPL(NUM_IMPL)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_idx(slot_idx), .wr_word(cfg_wdata),
    .rd_ok(slot_ok), .rd_idx(slot_idx), .rd_word(cfg_rdata),
    .entries(entries)
  );

  rsm_match #(.NUM_IMPL(NUM_IMPL)) u_match (
    .entries(entries), .rid(lk_rid),
    .match_vec(match_vec), .sel_onehot(sel_onehot),
    .any_match(any_match), .sel_sid(sel_sid)
  );

  // Result register: lookup sees the table as it stood before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_sid  <= '0;
      map_err <= 1'b0;
    end else begin
      lk_done <= lk_req;
      lk_hit  <= lk_req && any_match;
      lk_sid  <= (lk_req && any_match) ? sel_sid : '0;
      map_err <= lk_req && !any_match;
    end
  end
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int ADDR_W = 12,
  parameter int NUM_IMPL = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 12'h828
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   cfg_addr,
  input logic [31:0]         cfg_rdata,
  input logic                lk_req,
  input logic                lk_done,
  input logic                lk_hit,
  input logic [7:0]          lk_sid,
  input logic                map_err,
  input logic [NUM_IMPL-1:0] match_vec,
  input logic [NUM_IMPL-1:0] sel_onehot,
  input logic                any_match
);
  assert_done_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done);

  assert_hit_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && any_match) |=> (lk_hit && !map_err));

  assert_miss_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !any_match) |=> (map_err && !lk_hit && lk_sid == 8'h00));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_done && !lk_hit && !map_err && lk_sid == 8'h00));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[30:24] == 7'h00);

  assert_below_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < TABLE_BASE) |-> (cfg_rdata == 32'h0));

  assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot) && ((sel_onehot & ~match_vec) == '0) && (any_match == (sel_onehot != '0)));
endmodule

bind rid_sid_map rsm_checker #(
  .ADDR_W(ADDR_W), .NUM_IMPL(NUM_IMPL), .TABLE_BASE(TABLE_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lk_req(lk_req), .lk_done(lk_done), .lk_hit(lk_hit), .lk_sid(lk_sid),
  .map_err(map_err), .match_vec(match_vec), .sel_onehot(sel_onehot),
  .any_match(any_match)
);

// File: tb/tb_rid_sid_map.sv
module tb_rid_sid_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_req = 1'b0;
  logic [15:0] lk_rid = '0;
  logic        lk_done, lk_hit, map_err;
  logic [7:0]  lk_sid;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  rid_sid_map dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_req(lk_req),
    .lk_rid(lk_rid), .lk_done(lk_done), .lk_hit(lk_hit), .lk_sid(lk_sid),
    .map_err(map_err)
  );

  function automatic logic [11:0] slot_addr(int i);
    return 12'(12'h828 + 4 * i);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // Result packed as {done, hit, err, sid}
  task automatic lookup(logic [15:0] rid, output logic [10:0] res);
    @(negedge clk);
    lk_req = 1'b1; lk_rid = rid;
    @(negedge clk);
    lk_req = 1'b0;
    res = {lk_done, lk_hit, map_err, lk_sid};
  endtask

  // {rid, hit, sid}
  localparam logic [24:0] VEC [7] = '{
    {16'h0108, 1'b1, 8'h11},  // duplicate in slot 2, lowest wins
    {16'h0210, 1'b1, 8'h22},
    {16'h0A05, 1'b0, 8'h00},  // slot 3 not valid
    {16'hFFFF, 1'b1, 8'hFE},  // last implemented slot
    {16'h0109, 1'b0, 8'h00},  // one bit off in function
    {16'h8108, 1'b0, 8'h00},  // one bit off in bus
    {16'h0000, 1'b0, 8'h00}
  };

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [10:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(slot_addr(0), d);  check("R1 slot0 after reset", d, 32'h0);
    rd(slot_addr(15), d); check("R1 slot15 after reset", d, 32'h0);
    lookup(16'h0000, r);  check("R1 lookup misses after reset", 32'(r), {21'h0, 1'b1, 1'b0, 1'b1, 8'h00});
    @(negedge clk);
    check("R11 idle outputs", {28'h0, lk_done, lk_hit, map_err, |lk_sid}, 32'h0);

    // Program table
    wr(slot_addr(0), 32'h8011_0108);
    wr(slot_addr(1), 32'h8022_0210);
    wr(slot_addr(2), 32'h8033_0108);
    wr(slot_addr(3), 32'h0044_0A05);
    wr(slot_addr(15), 32'h80FE_FFFF);
    rd(slot_addr(0), d);  check("R2 readback slot0", d, 32'h8011_0108);
    rd(slot_addr(3), d);  check("R2 readback slot3", d, 32'h0044_0A05);

    // Vector walk: R5 R6 R7 R8 R9
    for (int i = 0; i < 7; i++) begin
      lookup(VEC[i][24:9], r);
      check($sformatf("R5/R6/R8/R9 vector %0d", i), 32'(r),
            {21'h0, 1'b1, VEC[i][8], ~VEC[i][8], VEC[i][7:0]});
    end

    // R3 reserved bits
    wr(slot_addr(4), 32'hFF55_1234);
    rd(slot_addr(4), d);  check("R3 reserved bits zero", d, 32'h8055_1234);

    // R4 unimplemented and out-of-window addresses
    wr(slot_addr(16), 32'h8077_4242);
    rd(slot_addr(16), d); check("R4 slot16 reads zero", d, 32'h0);
    lookup(16'h4242, r);  check("R4 slot16 write ignored", 32'(r), {21'h0, 1'b1, 1'b0, 1'b1, 8'h00});
    wr(slot_addr(63), 32'h8088_5151);
    rd(slot_addr(63), d); check("R4 slot63 reads zero", d, 32'h0);
    wr(12'h82A, 32'h8099_6161);
    rd(12'h82A, d);       check("R4 misaligned reads zero", d, 32'h0);
    rd(slot_addr(0), d);  check("R4 misaligned write left slot0", d, 32'h8011_0108);
    wr(12'h824, 32'h80AA_7171);
    rd(12'h824, d);       check("R4 below window reads zero", d, 32'h0);
    lookup(16'h7171, r);  check("R4 below-window write ignored", 32'(r), {21'h0, 1'b1, 1'b0, 1'b1, 8'h00});

    // R7 invalidate slot 0: slot 2 now wins (R8)
    wr(slot_addr(0), 32'h0);
    rd(slot_addr(0), d);  check("R7 slot0 cleared", d, 32'h0);
    lookup(16'h0108, r);  check("R7/R8 next slot wins", 32'(r), {21'h0, 1'b1, 1'b1, 1'b0, 8'h33});

    // R10 write and lookup on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = slot_addr(1); cfg_wdata = 32'h0;
    lk_req = 1'b1; lk_rid = 16'h0210;
    @(negedge clk);
    cfg_we = 1'b0; lk_req = 1'b0;
    check("R10 same-cycle lookup sees old entry", {21'h0, lk_done, lk_hit, map_err, lk_sid},
          {21'h0, 1'b1, 1'b1, 1'b0, 8'h22});
    lookup(16'h0210, r);  check("R10 following lookup misses", 32'(r), {21'h0, 1'b1, 1'b0, 1'b1, 8'h00});
    @(negedge clk);
    check("R6 error lasts one cycle", {31'h0, map_err}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule